// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the current word address for a four-beat memory burst. The upper address bits and a two-bit starting offset are captured when a burst begins. Every later beat derives the low two bits from that starting offset and a beat count. A burst begins when the controller strobe is sampled low. It also begins when the processor strobe is sampled low while the qualify input is high. Once a burst is running, an active-low advance input moves to the next beat. While advance is inactive the current address is held.

A static order input selects one of two beat orders. The interleaved order XORs the starting offset with the beat number. The linear order adds the beat number to the starting offset and wraps modulo four. Either way, the fifth beat returns to the starting address. The output is the registered upper bits concatenated with the generated low bits. It is valid one clock after the edge that loaded or stepped it.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `cur_addr` is all zeros from the following cycle.
- R2: When `ctrl_stb_n` is sampled low, `cur_addr` equals the sampled `addr_in` one cycle later, whatever the value of `proc_qual`.
- R3: When `proc_stb_n` is sampled low with `proc_qual` high, a load takes place as in R2. When `proc_stb_n` is low with `proc_qual` low and `ctrl_stb_n` high, no load takes place, and the cycle acts only on `adv_n`.
- R4: With no load, `adv_n` sampled low moves the burst one beat forward. With `adv_n` high, `cur_addr` keeps its value.
- R5: With `order_il` = 1 (interleaved), the low two bits of beat n (n = 0..3) are start XOR n.
- R6: With `order_il` = 0 (linear), the low two bits of beat n are (start + n) mod 4.
- R7: A fourth advance after beat 3 returns `cur_addr` to the address loaded at the start of the burst.
- R8: A load takes priority over an advance in the same cycle. The result is beat 0 of the newly loaded address.
- R9: The upper bits `cur_addr[ADDR_W-1:2]` change only on a load. Changes on `addr_in` with no strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_stb_n | input | 1 | Controller address strobe, active low, unqualified |
| proc_stb_n | input | 1 | Processor address strobe, active low, counts only when `proc_qual` is high |
| proc_qual | input | 1 | Qualify input for the processor strobe |
| adv_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear (held static) |
| addr_in | input | ADDR_W | External address, sampled on a load |
| cur_addr | output | ADDR_W | Current burst address |

## Verification
The assertions check on every cycle the load path (R2, R3 and R8) and the hold path of R4. They also check that the upper bits stay put without a load (R9), that the linear order steps by exactly one (R6), and that an interleaved step always changes the low bits. The full beat sequences, which depend on the starting offset, can only be shown by the bench's scenarios. These include the interleaved XOR pattern of R5 and the return to the starting address after four advances (R7). The bench runs every start value in both orders, with suspend cycles and stray address changes mixed in.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int LOW_W = 2;

    typedef logic [LOW_W-1:0] low_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } burst_act_e;

    typedef struct packed {
        low_t start;
        low_t beat;
    } burst_state_t;

    function automatic low_t seq_low(input logic interleave, input burst_state_t s);
        if (interleave)
            return s.start ^ s.beat;
        else
            return low_t'(s.start + s.beat);
    endfunction

endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl
    import burst_seq_pkg::*;
(
    input  logic       ctrl_stb_n,
    input  logic       proc_stb_n,
    input  logic       proc_qual,
    input  logic       adv_n,
    output burst_act_e act
);
    logic ctrl_hit;
    logic proc_hit;

    always_comb begin
        ctrl_hit = ~ctrl_stb_n;
        proc_hit = ~proc_stb_n & proc_qual;
        if (ctrl_hit || proc_hit)
            act = ACT_LOAD;
        else if (!adv_n)
            act = ACT_STEP;
        else
            act = ACT_HOLD;
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  burst_act_e   act,
    input  low_t         start_in,
    output burst_state_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    st.start <= start_in;
                    st.beat  <= '0;
                end
                ACT_STEP: st.beat <= low_t'(st.beat + 1'b1);
                default:  st <= st;
            endcase
        end
    end
endmodule

// File: rtl/burst_upper_reg.sv
module burst_upper_reg
    import burst_seq_pkg::*;
#(
    parameter int HI_W = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  burst_act_e      act,
    input  logic [HI_W-1:0] hi_in,
    output logic [HI_W-1:0] hi_q
);
    always_ff @(posedge clk) begin
        if (rst)
            hi_q <= '0;
        else if (act == ACT_LOAD)
            hi_q <= hi_in;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_stb_n,
    input  logic              proc_stb_n,
    input  logic              proc_qual,
    input  logic              adv_n,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int HI_W = ADDR_W - LOW_W;

    burst_act_e      act;
    burst_state_t    st;
    logic [HI_W-1:0] hi_q;

    burst_load_ctl u_ctl (
        .ctrl_stb_n (ctrl_stb_n),
        .proc_stb_n (proc_stb_n),
        .proc_qual  (proc_qual),
        .adv_n      (adv_n),
        .act        (act)
    );

    burst_beat_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .start_in (addr_in[LOW_W-1:0]),
        .st       (st)
    );

    burst_upper_reg #(.HI_W(HI_W)) u_hi (
        .clk   (clk),
        .rst   (rst),
        .act   (act),
        .hi_in (addr_in[ADDR_W-1:LOW_W]),
        .hi_q  (hi_q)
    );

    assign cur_addr = {hi_q, seq_low(order_il, st)};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ctrl_stb_n,
    input logic              proc_stb_n,
    input logic              proc_qual,
    input logic              adv_n,
    input logic              order_il,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] cur_addr
);
    logic ld;
    assign ld = !ctrl_stb_n || (!proc_stb_n && proc_qual);

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> cur_addr == '0);

    // R2, R3 and R8: any load, with or without advance, shows addr_in next cycle
    p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
        ld |=> cur_addr == $past(addr_in));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ld && adv_n) |=> (!$stable(order_il) || $stable(cur_addr)));

    p_upper_fixed_r9: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(cur_addr[ADDR_W-1:LOW_W]));

    p_linear_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!ld && !adv_n && !order_il) |=>
        (!$stable(order_il) ||
         cur_addr[LOW_W-1:0] == low_t'($past(cur_addr[LOW_W-1:0]) + 1'b1)));

    p_il_step_moves_r5: assert property (@(posedge clk) disable iff (rst)
        (!ld && !adv_n && order_il) |=>
        (!$stable(order_il) || !$stable(cur_addr[LOW_W-1:0])));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_stb_n (ctrl_stb_n),
    .proc_stb_n (proc_stb_n),
    .proc_qual  (proc_qual),
    .adv_n      (adv_n),
    .order_il   (order_il),
    .addr_in    (addr_in),
    .cur_addr   (cur_addr)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctrl_stb_n = 1'b1;
    logic          proc_stb_n = 1'b1;
    logic          proc_qual = 1'b0;
    logic          adv_n = 1'b1;
    logic          order_il = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] cur_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    // independent reference model
    logic [AW-3:0] m_hi;
    logic [1:0]    m_start;
    logic [1:0]    m_beat;

    burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
        .clk(clk), .rst(rst), .ctrl_stb_n(ctrl_stb_n), .proc_stb_n(proc_stb_n),
        .proc_qual(proc_qual), .adv_n(adv_n), .order_il(order_il),
        .addr_in(addr_in), .cur_addr(cur_addr)
    );

    always #5 clk = ~clk;

    task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: cur_addr=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one cycle and queue the expected result
    task automatic step(input logic cs_n, input logic ps_n, input logic q,
                        input logic av_n, input logic [AW-1:0] a, input string tag);
        logic [1:0] lo;
        @(negedge clk);
        ctrl_stb_n = cs_n; proc_stb_n = ps_n; proc_qual = q; adv_n = av_n; addr_in = a;
        if (!cs_n || (!ps_n && q)) begin
            m_hi = a[AW-1:2]; m_start = a[1:0]; m_beat = 2'd0;
        end else if (!av_n) begin
            m_beat = m_beat + 2'd1;
        end
        lo = order_il ? (m_start ^ m_beat) : (m_start + m_beat);
        exp_q.push_back({m_hi, lo});
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [AW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(cur_addr, e, t);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_hi = '0; m_start = '0; m_beat = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(cur_addr, '0, "R1 reset value");

        for (int m = 0; m < 2; m++) begin
            @(negedge clk);
            order_il = m[0];
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] base;
                base = {AW'(16'h3A5 + s * 16'h111)} << 2 | AW'(s);
                step(1'b0, 1'b1, 1'b0, 1'b1, base, "R2 controller load");
                for (int b = 1; b <= 4; b++) begin
                    step(1'b1, 1'b1, 1'b0, 1'b0, ~base,
                         b == 4 ? "R7 wrap to start" : (m == 1 ? "R5 interleaved beat" : "R6 linear beat"));
                    step(1'b1, 1'b1, 1'b1, 1'b1, base ^ 16'hFFF0, "R4 suspend hold / R9 upper fixed");
                end
            end
        end

        // R3: unqualified processor strobe does not load; it only advances
        order_il = 1'b0;
        step(1'b0, 1'b1, 1'b0, 1'b1, 16'h1231, "R2 load before R3");
        step(1'b1, 1'b0, 1'b0, 1'b0, 16'hBEE2, "R3 unqualified strobe ignored");
        step(1'b1, 1'b0, 1'b0, 1'b1, 16'hBEE3, "R3 unqualified strobe hold");
        step(1'b1, 1'b0, 1'b1, 1'b1, 16'h4563, "R3 qualified processor load");
        step(1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, "R6 step after processor load");
        // R8: load wins over advance
        step(1'b0, 1'b1, 1'b0, 1'b0, 16'h7772, "R8 load beats advance");
        step(1'b1, 1'b0, 1'b1, 1'b0, 16'h8881, "R8 processor load beats advance");
        step(1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, "R6 step after R8 load");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule